// File: doc/BRIEF.md
# Comma Detector and Character Framer

This block sits behind a clock-and-data recovery stage and takes one recovered line bit per clock. It watches the bit stream for the positive-disparity comma prefix. From it, the block cuts the stream into 10-bit characters whose boundaries follow the most recent comma it accepted. Each finished character is presented on a parallel bus with a one-cycle valid strobe. A separate flag marks the characters that are commas.

Comma hunting is gated by a search enable. While the enable is low, the current boundary stays where it is. When a comma turns up off the current boundary, the block moves the boundary at once. The comma itself is emitted, flagged, as the first character on the new boundary. The partial character that was being built is dropped. A loss-of-signal input replaces the character data with all ones.

Top module: `comma_frame_aligner`

## Requirements
- R1: Output bit k of a character is the k-th bit of that character to arrive. On a settled boundary, characters appear one per 10 bit clocks, each with `char_valid` high for exactly one cycle.
- R2: A comma is a character whose first seven arriving bits are 0,0,1,1,1,1,1, which means `char_data[6:0] == 7'b1111100`. Bits 9:7 are ignored. Near-miss patterns are not flagged.
- R3: When search is enabled and a comma completes off the current boundary, the boundary moves. The comma is emitted flagged in the cycle after the one in which its tenth bit is registered, and every following character is aligned to it.
- R4: A comma that completes on the current boundary causes no realignment. No character is lost, duplicated or added.
- R5: While `search_en` was low when a character's last bit was presented, no comma is flagged and the boundary is kept, even if the stream has slipped.
- R6: `char_comma` is high only together with `char_valid`, for the one character that is the comma.
- R7: A character whose last bit was presented while `sig_lost` was high comes out as all ones, with `char_comma` low. Its cadence and the boundary are unaffected.
- R8: During and after synchronous reset, `char_valid`, `char_comma` and `char_data` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Recovered line bit, one per clock |
| search_en | input | 1 | Enables comma hunting and realignment |
| sig_lost | input | 1 | Loss-of-signal indication |
| char_data | output | 10 | Deframed character; bit 0 arrived first |
| char_valid | output | 1 | One-cycle strobe per character |
| char_comma | output | 1 | Marks the character that is a comma |

## Verification
If the phase counter or the bit window goes wrong, the boundary shifts. That shows up on the very next character as rotated data, or as a strobe that arrives early or late. A scoreboard that compares every character in order therefore catches it within ten bit clocks. A wrong decision to realign either drops characters or adds a spurious one, so the bench checks the order and count of characters after every comma, with and without search enabled. A stale loss-of-signal or enable sample shows as a wrong character at the edges where those inputs change, and the stimulus switches them exactly on character boundaries.

// File: rtl/fa_pkg.sv
package fa_pkg;
    localparam int CHAR_W = 10;
    localparam int MARK_W = 7;
    // bit k holds the k-th arriving bit of the prefix 0,0,1,1,1,1,1
    localparam logic [MARK_W-1:0] MARK_BITS = 7'b1111100;

    typedef logic [CHAR_W-1:0] char_t;

    typedef struct packed {
        logic  vld;
        logic  mark;
        char_t data;
    } char_beat_t;

    function automatic logic mark_match(input char_t win);
        return win[MARK_W-1:0] == MARK_BITS;
    endfunction
endpackage

// File: rtl/fa_shifter.sv
module fa_shifter
    import fa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_i,
    input  logic  en_i,
    input  logic  los_i,
    output char_t win_o,
    output logic  en_q_o,
    output logic  los_q_o
);
    // newest bit enters at the top, so win_o[0] is the oldest bit
    always_ff @(posedge clk) begin
        if (rst) begin
            win_o   <= '1;
            en_q_o  <= 1'b0;
            los_q_o <= 1'b0;
        end else begin
            win_o   <= {bit_i, win_o[CHAR_W-1:1]};
            en_q_o  <= en_i;
            los_q_o <= los_i;
        end
    end
endmodule

// File: rtl/fa_phase.sv
module fa_phase
    import fa_pkg::*;
#(
    parameter int CW = CHAR_W
) (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    output logic ready_o
);
    localparam int PW = $clog2(CW);
    localparam logic [PW-1:0] LAST = PW'(CW - 1);

    logic [PW-1:0] cnt;

    assign ready_o = (cnt == LAST) || hit_i;

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (ready_o) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    // R3: an accepted comma restarts the character phase
    assert_realign_restarts_R3: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> (cnt == '0));
endmodule

// File: rtl/fa_emit.sv
module fa_emit
    import fa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ready_i,
    input  logic       hit_i,
    input  logic       los_i,
    input  char_t      win_i,
    output char_beat_t beat_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_o <= '0;
        end else if (ready_i) begin
            beat_o.vld  <= 1'b1;
            beat_o.mark <= hit_i && !los_i;
            beat_o.data <= los_i ? '1 : win_i;
        end else begin
            beat_o.vld  <= 1'b0;
            beat_o.mark <= 1'b0;
        end
    end

    assert_flag_with_valid_R6: assert property (@(posedge clk) disable iff (rst)
        beat_o.mark |-> beat_o.vld);

    assert_flag_pattern_R2: assert property (@(posedge clk) disable iff (rst)
        beat_o.mark |-> (beat_o.data[MARK_W-1:0] == MARK_BITS));

    assert_los_ones_R7: assert property (@(posedge clk) disable iff (rst)
        (ready_i && los_i) |=> (beat_o.data == '1 && !beat_o.mark));
endmodule

// File: rtl/comma_frame_aligner.sv
module comma_frame_aligner
    import fa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit,
    input  logic              search_en,
    input  logic              sig_lost,
    output logic [CHAR_W-1:0] char_data,
    output logic              char_valid,
    output logic              char_comma
);
    char_t      win;
    logic       en_q;
    logic       los_q;
    logic       hit;
    logic       ready;
    char_beat_t beat;

    fa_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (rx_bit),
        .en_i   (search_en),
        .los_i  (sig_lost),
        .win_o  (win),
        .en_q_o (en_q),
        .los_q_o(los_q)
    );

    assign hit = en_q && mark_match(win);

    fa_phase #(.CW(CHAR_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (hit),
        .ready_o(ready)
    );

    fa_emit u_emit (
        .clk    (clk),
        .rst    (rst),
        .ready_i(ready),
        .hit_i  (hit),
        .los_i  (los_q),
        .win_i  (win),
        .beat_o (beat)
    );

    assign char_data  = beat.data;
    assign char_valid = beat.vld;
    assign char_comma = beat.mark;

    // R5: with search disabled no comma is ever flagged
    assert_no_flag_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        (ready && !en_q) |=> !char_comma);
endmodule

// File: tb/tb_comma_frame_aligner.sv
module tb_comma_frame_aligner;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b0;
    logic       search_en = 1'b1;
    logic       sig_lost = 1'b0;
    logic [9:0] char_data;
    logic       char_valid;
    logic       char_comma;

    typedef struct {
        logic [9:0] d;
        logic       c;
        string      tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int hunt_gen = 1;
    int seen_gen = 0;
    bit done = 1'b0;

    localparam logic [9:0] K_A  = 10'b0101111100;
    localparam logic [9:0] K_B  = 10'b1011111100;
    localparam logic [9:0] NM_A = 10'b0101111101;
    localparam logic [9:0] NM_B = 10'b0100111100;

    always #4 clk = ~clk;

    comma_frame_aligner dut (
        .clk       (clk),
        .rst       (rst),
        .rx_bit    (rx_bit),
        .search_en (search_en),
        .sig_lost  (sig_lost),
        .char_data (char_data),
        .char_valid(char_valid),
        .char_comma(char_comma)
    );

    task automatic chk(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected characters as the design emits them
    always @(negedge clk) begin
        if (!rst && char_valid) begin
            if (seen_gen != hunt_gen && !char_comma) begin
                // still hunting: output before the realigning comma is don't-care
            end else begin
                seen_gen = hunt_gen;
                if (q.size() == 0) begin
                    chk(1'b0, "R4 unexpected extra character", char_data, 10'h0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(char_data == e.d, {e.tag, " data"}, char_data, e.d);
                    chk(char_comma == e.c, {e.tag, " comma flag"}, {9'b0, char_comma}, {9'b0, e.c});
                end
            end
        end
    end

    function automatic logic [9:0] dgen();
        logic [9:0] r;
        r = 10'($urandom);
        r[2] = 1'b0; r[5] = 1'b0; r[8] = 1'b0;
        return r;
    endfunction

    task automatic send_bit(input logic b);
        rx_bit = b;
        @(negedge clk);
    endtask

    task automatic push(input logic [9:0] d, input logic c, input string tag);
        exp_t e;
        e.d = d; e.c = c; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic send_char(input logic [9:0] c);
        for (int i = 0; i < 10; i++) send_bit(c[i]);
    endtask

    task automatic drain();
        int n = 0;
        while (q.size() != 0 && n < 40) begin
            send_bit(1'b0);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [9:0] d;
        logic [9:0] prev9;
        @(negedge clk);
        @(negedge clk);
        // R8: reset state
        chk(char_valid == 1'b0, "R8 valid in reset", {9'b0, char_valid}, 10'h0);
        chk(char_comma == 1'b0, "R8 comma in reset", {9'b0, char_comma}, 10'h0);
        chk(char_data == 10'h0, "R8 data in reset", char_data, 10'h0);
        @(negedge clk);
        rst = 1'b0;
        chk(char_valid == 1'b0 && char_data == 10'h0, "R8 state after reset", char_data, 10'h0);

        // R3: initial lock from an arbitrary offset
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        repeat (3) send_char(dgen());
        push(K_A, 1'b1, "R3 first comma");
        send_char(K_A);
        repeat (6) begin
            d = dgen(); push(d, 1'b0, "R1 aligned data"); send_char(d);
        end

        // R4/R6: comma on the current boundary
        push(K_A, 1'b1, "R4 aligned comma");
        send_char(K_A);
        repeat (3) begin
            d = dgen(); push(d, 1'b0, "R6 data after comma"); send_char(d);
        end
        // R2: near misses and a comma with different tail bits
        push(NM_A, 1'b0, "R2 near miss first bit"); send_char(NM_A);
        push(NM_B, 1'b0, "R2 near miss seventh bit"); send_char(NM_B);
        push(K_B, 1'b1, "R2 comma other tail"); send_char(K_B);
        d = dgen(); push(d, 1'b0, "R2 data"); send_char(d);

        // R5: search disabled, aligned comma is not flagged
        search_en = 1'b0;
        push(K_A, 1'b0, "R5 comma with search off"); send_char(K_A);
        // R5: slip one bit; boundary must stay put
        send_bit(1'b0);
        prev9 = 1'b0;
        for (int k = 0; k < 4; k++) begin
            d = (k == 0) ? K_A : dgen();
            push({d[8:0], prev9[0]}, 1'b0, "R5 boundary kept after slip");
            send_char(d);
            prev9 = {9'b0, d[9]};
        end
        drain();

        // R3: re-lock on the fly after search is enabled again
        hunt_gen = hunt_gen + 1;
        search_en = 1'b1;
        repeat (2) send_char(dgen());
        push(K_B, 1'b1, "R3 realign comma"); send_char(K_B);
        repeat (3) begin
            d = dgen(); push(d, 1'b0, "R3 data after realign"); send_char(d);
        end

        // R7: loss of signal
        sig_lost = 1'b1;
        push(10'h3FF, 1'b0, "R7 los data"); send_char(dgen());
        push(10'h3FF, 1'b0, "R7 los on comma"); send_char(K_A);
        push(10'h3FF, 1'b0, "R7 los data"); send_char(dgen());
        sig_lost = 1'b0;
        d = dgen(); push(d, 1'b0, "R7 boundary after los"); send_char(d);
        push(K_A, 1'b1, "R7 comma after los"); send_char(K_A);
        d = dgen(); push(d, 1'b0, "R1 tail data"); send_char(d);
        drain();

        chk(q.size() == 0, "R4 all characters delivered", 10'(q.size()), 10'h0);
        done = 1'b1;
        finish_run();
    end
endmodule